// File: doc/BRIEF.md
# Receive Flow-Control Interrupt Flags

This block holds three pending interrupt flags on the receive side of a serial port: one for a received Xoff character, one for a received Xon character, and one for a received special character. A character comparator upstream compares each received character against the programmed values and raises match flags next to the receiver's character-valid strobe. This block turns those matches into sticky flags. It clears the flags when the host reads the interrupt status register, or when later receive events clear them on their own. A combined, maskable interrupt request is driven from the three flags.

A one-bit clear-mode select picks how the Xoff and special-character flags go away. In self-clear mode (0), a received Xon character also drops the Xoff flag, and any later character drops the special-character flag. In read-only mode (1), only a status read clears them. The Xon flag always waits for a status read. When a set event and a clear event meet in the same cycle, the set wins. As a result, the character that raises the special flag never clears it, and no match is lost.

Top module: `flowIrqClear`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves all three pending flags at 0, and `irq` at 0, after that edge.
- R2: A match input counts only in a cycle where `rxValid` is 1. It then sets its flag at the next clock edge. A match input with `rxValid` at 0 has no effect.
- R3: The Xon flag is cleared only by an `isrRead` pulse, in either clear mode. No received character clears it.
- R4: With `clearMode` = 0, the Xoff flag clears at the edge after an `isrRead` pulse, or after a valid character that matches Xon.
- R5: With `clearMode` = 0, the special flag clears at the edge after an `isrRead` pulse, or after any valid character received later. The character that sets the flag does not clear it.
- R6: With `clearMode` = 1, the Xoff and special flags clear only on an `isrRead` pulse. Valid characters do not clear them.
- R7: When a set event and a clear event for the same flag occur in the same cycle, the flag is 1 after the edge.
- R8: `irq` is 1 exactly when at least one pending flag is 1 with its enable input (`enXon`, `enXoff`, `enSpecial`) also at 1. It follows the flags in the same cycle, with no extra register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxValid | input | 1 | One-cycle strobe: a received character is present |
| isXon | input | 1 | Comparator says the character is the Xon value |
| isXoff | input | 1 | Comparator says the character is the Xoff value |
| isSpecial | input | 1 | Comparator says the character is the special value |
| isrRead | input | 1 | One-cycle strobe: host read the interrupt status register |
| clearMode | input | 1 | 0 = self-clear on receive events, 1 = clear on status read only |
| enXon | input | 1 | Interrupt enable for the Xon flag |
| enXoff | input | 1 | Interrupt enable for the Xoff flag |
| enSpecial | input | 1 | Interrupt enable for the special flag |
| xonPending | output | 1 | Xon-received flag |
| xoffPending | output | 1 | Xoff-received flag |
| specialPending | output | 1 | Special-character-received flag |
| irq | output | 1 | Combined masked interrupt request |

## Verification
Each flag takes the result of a stimulus cycle one clock edge later, and `irq` follows the flags in the same cycle with no extra delay. The bench drives inputs on the falling edge. It places every stimulus in a single cycle between a reset-plus-preload cycle and an idle cycle. It then samples flags and `irq` at the next falling edge, which comes after exactly one rising edge. The sweep covers both clear modes, all eight preloaded flag states and all 32 combinations of the five event inputs. The enables rotate from one vector to the next, so that every kind of clear, every same-cycle set-and-clear collision and every mask pattern is met.

// File: rtl/flow_irq_pkg.sv
package flow_irq_pkg;
  localparam int FLAG_COUNT   = 3;
  localparam int FLAG_XON     = 0;
  localparam int FLAG_XOFF    = 1;
  localparam int FLAG_SPECIAL = 2;

  // Strobes from control to flag datapath: one set and one clear per flag.
  typedef struct packed {
    logic [FLAG_COUNT-1:0] set;
    logic [FLAG_COUNT-1:0] clr;
  } flagStrobes_t;
endpackage

// File: rtl/flowIrqCtrl.sv
module flowIrqCtrl
  import flow_irq_pkg::*;
(
  input  logic         rxValid,
  input  logic         isXon,
  input  logic         isXoff,
  input  logic         isSpecial,
  input  logic         isrRead,
  input  logic         clearMode,
  output flagStrobes_t strobes
);
  logic [FLAG_COUNT-1:0] matchVec;
  logic [FLAG_COUNT-1:0] selfClr;
  logic                  selfClrAllowed;

  always_comb begin
    matchVec               = '0;
    matchVec[FLAG_XON]     = isXon;
    matchVec[FLAG_XOFF]    = isXoff;
    matchVec[FLAG_SPECIAL] = isSpecial;

    selfClrAllowed = ~clearMode & rxValid;

    // Xon never self-clears; Xoff drops on a received Xon; special drops on any character.
    selfClr               = '0;
    selfClr[FLAG_XOFF]    = selfClrAllowed & isXon;
    selfClr[FLAG_SPECIAL] = selfClrAllowed;

    strobes.set = rxValid ? matchVec : '0;
    strobes.clr = {FLAG_COUNT{isrRead}} | selfClr;
  end
endmodule

// File: rtl/flowIrqFlags.sv
module flowIrqFlags
  import flow_irq_pkg::*;
#(
  parameter int NUM_FLAGS = FLAG_COUNT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  flagStrobes_t         strobes,
  input  logic [NUM_FLAGS-1:0] enable,
  output logic [NUM_FLAGS-1:0] pending,
  output logic                 irq
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                  pending[i] <= 1'b0;
      else if (strobes.set[i])  pending[i] <= 1'b1;   // set wins over clear
      else if (strobes.clr[i])  pending[i] <= 1'b0;
    end
  end

  assign irq = |(pending & enable);
endmodule

// File: rtl/flowIrqClear.sv
module flowIrqClear
  import flow_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rxValid,
  input  logic isXon,
  input  logic isXoff,
  input  logic isSpecial,
  input  logic isrRead,
  input  logic clearMode,
  input  logic enXon,
  input  logic enXoff,
  input  logic enSpecial,
  output logic xonPending,
  output logic xoffPending,
  output logic specialPending,
  output logic irq
);
  flagStrobes_t          strobes;
  logic [FLAG_COUNT-1:0] enableVec;
  logic [FLAG_COUNT-1:0] pendingVec;

  always_comb begin
    enableVec               = '0;
    enableVec[FLAG_XON]     = enXon;
    enableVec[FLAG_XOFF]    = enXoff;
    enableVec[FLAG_SPECIAL] = enSpecial;
  end

  flowIrqCtrl u_ctrl (
    .rxValid  (rxValid),
    .isXon    (isXon),
    .isXoff   (isXoff),
    .isSpecial(isSpecial),
    .isrRead  (isrRead),
    .clearMode(clearMode),
    .strobes  (strobes)
  );

  flowIrqFlags #(.NUM_FLAGS(FLAG_COUNT)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .enable (enableVec),
    .pending(pendingVec),
    .irq    (irq)
  );

  assign xonPending     = pendingVec[FLAG_XON];
  assign xoffPending    = pendingVec[FLAG_XOFF];
  assign specialPending = pendingVec[FLAG_SPECIAL];
endmodule

// File: rtl/flowIrqClear_checker.sv
module flowIrqClear_checker (
  input logic clk,
  input logic rst,
  input logic rxValid,
  input logic isXon,
  input logic isXoff,
  input logic isSpecial,
  input logic isrRead,
  input logic clearMode,
  input logic enXon,
  input logic enXoff,
  input logic enSpecial,
  input logic xonPending,
  input logic xoffPending,
  input logic specialPending,
  input logic irq
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!xonPending && !xoffPending && !specialPending && !irq));

  assert_match_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (rxValid && isXon) |=> xonPending);

  assert_xon_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (xonPending && !isrRead) |=> xonPending);

  assert_xoff_on_xon_R4: assert property (@(posedge clk) disable iff (rst)
    (!clearMode && rxValid && isXon && !isXoff) |=> !xoffPending);

  assert_special_next_char_R5: assert property (@(posedge clk) disable iff (rst)
    (!clearMode && rxValid && !isSpecial) |=> !specialPending);

  assert_xoff_read_only_R6: assert property (@(posedge clk) disable iff (rst)
    (clearMode && xoffPending && !isrRead) |=> xoffPending);

  assert_special_read_only_R6: assert property (@(posedge clk) disable iff (rst)
    (clearMode && specialPending && !isrRead) |=> specialPending);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rxValid && isSpecial && isXoff && isrRead) |=> (specialPending && xoffPending));

  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!xonPending && !xoffPending && !specialPending) |-> !irq);

  assert_irq_xon_R8: assert property (@(posedge clk) disable iff (rst)
    (xonPending && enXon) |-> irq);

  assert_irq_xoff_R8: assert property (@(posedge clk) disable iff (rst)
    (xoffPending && enXoff) |-> irq);

  assert_irq_special_R8: assert property (@(posedge clk) disable iff (rst)
    (specialPending && enSpecial) |-> irq);
endmodule

bind flowIrqClear flowIrqClear_checker chk (.*);

// File: tb/flowIrqClear_test.sv
`timescale 1ns/1ps
module flowIrqClear_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxValid = 1'b0, isXon = 1'b0, isXoff = 1'b0, isSpecial = 1'b0;
  logic isrRead = 1'b0, clearMode = 1'b0;
  logic enXon = 1'b1, enXoff = 1'b1, enSpecial = 1'b1;
  logic xonPending, xoffPending, specialPending, irq;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  flowIrqClear uut (.*);

  task automatic checkBit(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    rxValid = 1'b0; isXon = 1'b0; isXoff = 1'b0; isSpecial = 1'b0; isrRead = 1'b0;
  endtask

  function automatic string flagTag(input bit setEv, input bit clrEv, input string plain);
    if (setEv && clrEv) return "R7";
    if (setEv)          return "R2";
    return plain;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    for (int m = 0; m < 2; m++) begin
      for (int init = 0; init < 8; init++) begin
        for (int stim = 0; stim < 32; stim++) begin
          logic [2:0] initV, setV, clrV, expV, enV;
          bit rv, xn, xf, sp, rd;
          // Reset cycle
          @(negedge clk);
          rst = 1'b1; idleInputs(); clearMode = m[0];
          enXon = 1'b1; enXoff = 1'b1; enSpecial = 1'b1;
          // Preload cycle: check reset state first (R1)
          @(negedge clk);
          rst = 1'b0;
          checkBit(xonPending, 1'b0, "R1", "xon after reset");
          checkBit(xoffPending, 1'b0, "R1", "xoff after reset");
          checkBit(specialPending, 1'b0, "R1", "special after reset");
          checkBit(irq, 1'b0, "R1", "irq after reset");
          initV = init[2:0];
          rxValid = 1'b1; isXon = initV[0]; isXoff = initV[1]; isSpecial = initV[2];
          // Stimulus cycle: check preload (R2)
          @(negedge clk);
          checkBit(xonPending, initV[0], "R2", "xon preload");
          checkBit(xoffPending, initV[1], "R2", "xoff preload");
          checkBit(specialPending, initV[2], "R2", "special preload");
          rv = stim[0]; xn = stim[1]; xf = stim[2]; sp = stim[3]; rd = stim[4];
          rxValid = rv; isXon = xn; isXoff = xf; isSpecial = sp; isrRead = rd;
          enV = 3'((init + stim + m) % 8);
          enXon = enV[0]; enXoff = enV[1]; enSpecial = enV[2];
          // Expected from the requirements
          setV = rv ? {sp, xf, xn} : 3'b000;
          clrV[0] = rd;
          clrV[1] = rd | (m == 0 && rv && xn);
          clrV[2] = rd | (m == 0 && rv);
          expV = setV | (initV & ~clrV);
          // Result cycle
          @(negedge clk);
          idleInputs();
          checkBit(xonPending, expV[0], flagTag(setV[0], clrV[0], "R3"), "xon");
          checkBit(xoffPending, expV[1], flagTag(setV[1], clrV[1], m ? "R6" : "R4"), "xoff");
          checkBit(specialPending, expV[2], flagTag(setV[2], clrV[2], m ? "R6" : "R5"), "special");
          checkBit(irq, |(expV & enV), "R8", "irq");
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule